// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two parallel data buses, called A and B, of parameterized width (8 bits by default). It can pass data between them without inverting it. It also keeps one storage register per side. The A-side register takes a snapshot of the A bus, and the B-side register takes a snapshot of the B bus. Each register has its own capture strobe, and a register loads when its strobe goes from high to low. Each strobe is sampled on the system clock, so the falling edge is detected synchronously.

An active-low enable and a direction input decide which bus is driven, if any. Direction high drives B and direction low drives A. Two select inputs, one for each direction, choose what the driven bus carries. Select value 0 picks the live value from the opposite bus. Select value 1 picks the stored register of the opposite side.

Each bus is modelled as three ports: an input, an output and an output-enable. A bus that is not driven shows zero on its output and a low enable. This stands in for high impedance.

Top module: `bus_xcvr_reg`

## Requirements
- R1: A synchronous active-high reset clears both storage registers to 0. After reset, a driven output that selects stored data reads 0.
- R2: While `oe_n` is 1, both `a_oe` and `b_oe` are 0 and both `a_out` and `b_out` are 0.
- R3: While `oe_n` is 0, `dir`=1 sets `b_oe`=1 and `a_oe`=0, and `dir`=0 sets `a_oe`=1 and `b_oe`=0. `a_oe` and `b_oe` are never both 1.
- R4: While B is driven, `sel_ab`=0 puts `a_in` on `b_out` unchanged in the same cycle. `sel_ab`=1 puts the stored A register on `b_out`.
- R5: While A is driven, `sel_ba`=0 puts `b_in` on `a_out` unchanged in the same cycle. `sel_ba`=1 puts the stored B register on `a_out`.
- R6: Take a rising clock edge at which `cap_a` is sampled 0, when it was sampled 1 at the previous rising edge. At that edge the A register loads the A-bus value. The new value is visible from that edge on. `cap_b` does the same for the B register and the B bus.
- R7: A register does not change at any rising clock edge where its strobe has not fallen, including the edge where the strobe rises or stays high.
- R8: Both registers load on a falling strobe whatever the values of `oe_n`, `dir` and the selects.
- R9: The A-bus value captured is `a_out` when `a_oe` is 1, and `a_in` otherwise. The B-bus value is chosen in the same way from `b_out` and `b_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| oe_n | input | 1 | Output enable, active low |
| dir | input | 1 | 1: drive B from A side, 0: drive A from B side |
| sel_ab | input | 1 | Source for B bus: 0 live A, 1 stored A |
| sel_ba | input | 1 | Source for A bus: 0 live B, 1 stored B |
| cap_a | input | 1 | A-register capture strobe, falling edge |
| cap_b | input | 1 | B-register capture strobe, falling edge |
| a_in | input | W | Value seen on the A bus from outside |
| a_out | output | W | Value this block drives onto the A bus |
| a_oe | output | 1 | A-bus driver enable |
| b_in | input | W | Value seen on the B bus from outside |
| b_out | output | W | Value this block drives onto the B bus |
| b_oe | output | 1 | B-bus driver enable |

## Verification
The following properties are checked on every cycle:
- the two driver enables are mutually exclusive and follow `oe_n` and `dir`;
- outputs are zero while disabled;
- each driven output matches its selected live or stored source;
- each register loads the captured bus value exactly after a sampled strobe fall and holds otherwise.

Only the bench's scenarios show the following:
- the reset value;
- all sixteen enable, direction and select combinations with distinct data on both buses;
- loading while outputs are disabled;
- no load when a strobe rises or stays high;
- capture of the block's own driven value while A is driven.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_sel_e;

  localparam int NUM_SIDES = 2;
  localparam int SIDE_A = 0;
  localparam int SIDE_B = 1;
endpackage

// File: rtl/xcvr_fall_detect.sv
module xcvr_fall_detect (
  input  logic clk,
  input  logic strobe,
  output logic fall
);
  logic strobe_q;

  // Tracks the strobe also during reset, so the first edge after reset is seen.
  always_ff @(posedge clk) begin
    strobe_q <= strobe;
  end

  assign fall = strobe_q & ~strobe;
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (load) begin
      q <= d;
    end
  end
endmodule

// File: rtl/xcvr_path.sv
module xcvr_path #(
  parameter int W = 8
) (
  input  logic         drive,
  input  logic         sel,
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  output logic [W-1:0] out
);
  import xcvr_pkg::*;

  src_sel_e src;
  assign src = src_sel_e'(sel);

  always_comb begin
    if (!drive) begin
      out = '0;
    end else if (src == SRC_STORED) begin
      out = stored;
    end else begin
      out = live;
    end
  end
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         oe_n,
  input  logic         dir,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic         cap_a,
  input  logic         cap_b,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe
);
  import xcvr_pkg::*;

  logic [W-1:0] bus_in   [NUM_SIDES];
  logic [W-1:0] bus_out  [NUM_SIDES];
  logic [W-1:0] captured [NUM_SIDES];
  logic [W-1:0] stored_q [NUM_SIDES];
  logic         drive    [NUM_SIDES];
  logic         strobe   [NUM_SIDES];
  logic         fall     [NUM_SIDES];
  logic         sel_to   [NUM_SIDES];

  assign bus_in[SIDE_A] = a_in;
  assign bus_in[SIDE_B] = b_in;
  assign strobe[SIDE_A] = cap_a;
  assign strobe[SIDE_B] = cap_b;
  assign drive[SIDE_A]  = ~oe_n & ~dir;
  assign drive[SIDE_B]  = ~oe_n &  dir;
  // Select for the bus being driven: A gets sel_ba, B gets sel_ab.
  assign sel_to[SIDE_A] = sel_ba;
  assign sel_to[SIDE_B] = sel_ab;

  genvar g;
  generate
    for (g = 0; g < NUM_SIDES; g++) begin : g_side
      localparam int OTHER = NUM_SIDES - 1 - g;

      // Value present on bus g: our own drive when enabled, else external.
      assign captured[g] = drive[g] ? bus_out[g] : bus_in[g];

      xcvr_fall_detect u_fall (
        .clk    (clk),
        .strobe (strobe[g]),
        .fall   (fall[g])
      );

      xcvr_store #(.W(W)) u_store (
        .clk  (clk),
        .rst  (rst),
        .load (fall[g]),
        .d    (captured[g]),
        .q    (stored_q[g])
      );

      // Output of bus g comes from the opposite side's live bus or register.
      xcvr_path #(.W(W)) u_path (
        .drive  (drive[g]),
        .sel    (sel_to[g]),
        .live   (bus_in[OTHER]),
        .stored (stored_q[OTHER]),
        .out    (bus_out[g])
      );
    end
  endgenerate

  assign a_out = bus_out[SIDE_A];
  assign b_out = bus_out[SIDE_B];
  assign a_oe  = drive[SIDE_A];
  assign b_oe  = drive[SIDE_B];
endmodule

// File: rtl/bus_xcvr_reg_chk.sv
module bus_xcvr_reg_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         oe_n,
  input logic         dir,
  input logic         sel_ab,
  input logic         sel_ba,
  input logic         cap_a,
  input logic         cap_b,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_out,
  input logic         a_oe,
  input logic [W-1:0] b_in,
  input logic [W-1:0] b_out,
  input logic         b_oe,
  input logic [W-1:0] st_a,
  input logic [W-1:0] st_b
);
  assert_one_driver_R3: assert property (@(posedge clk) disable iff (rst)
    !(a_oe && b_oe));

  assert_dir_R3: assert property (@(posedge clk) disable iff (rst)
    !oe_n |-> (b_oe == dir && a_oe == !dir));

  assert_hiz_R2: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> (!a_oe && !b_oe && a_out == '0 && b_out == '0));

  assert_live_b_R4: assert property (@(posedge clk) disable iff (rst)
    (b_oe && !sel_ab) |-> (b_out == a_in));

  assert_stored_b_R4: assert property (@(posedge clk) disable iff (rst)
    (b_oe && sel_ab) |-> (b_out == st_a));

  assert_live_a_R5: assert property (@(posedge clk) disable iff (rst)
    (a_oe && !sel_ba) |-> (a_out == b_in));

  assert_stored_a_R5: assert property (@(posedge clk) disable iff (rst)
    (a_oe && sel_ba) |-> (a_out == st_b));

  // R6 and R9: load of the bus value as seen at the fall
  assert_load_a_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(cap_a) && !cap_a) |=> (st_a == $past(a_oe ? a_out : a_in)));

  assert_load_b_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(cap_b) && !cap_b) |=> (st_b == $past(b_oe ? b_out : b_in)));

  assert_hold_a_R7: assert property (@(posedge clk) disable iff (rst)
    !($past(cap_a) && !cap_a) |=> $stable(st_a));

  assert_hold_b_R7: assert property (@(posedge clk) disable iff (rst)
    !($past(cap_b) && !cap_b) |=> $stable(st_b));
endmodule

bind bus_xcvr_reg bus_xcvr_reg_chk #(.W(W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .oe_n   (oe_n),
  .dir    (dir),
  .sel_ab (sel_ab),
  .sel_ba (sel_ba),
  .cap_a  (cap_a),
  .cap_b  (cap_b),
  .a_in   (a_in),
  .a_out  (a_out),
  .a_oe   (a_oe),
  .b_in   (b_in),
  .b_out  (b_out),
  .b_oe   (b_oe),
  .st_a   (stored_q[0]),
  .st_b   (stored_q[1])
);

// File: tb/test_bus_xcvr_reg.sv
module test_bus_xcvr_reg;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst, oe_n, dir, sel_ab, sel_ba, cap_a, cap_b;
  logic [W-1:0] a_in, b_in, a_out, b_out;
  logic a_oe, b_oe;

  always #2.5 clk = ~clk;

  bus_xcvr_reg #(.W(W)) i_bus_xcvr_reg (
    .clk(clk), .rst(rst), .oe_n(oe_n), .dir(dir),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .cap_a(cap_a), .cap_b(cap_b),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  typedef struct packed {
    logic         a_oe;
    logic         b_oe;
    logic [W-1:0] a_out;
    logic [W-1:0] b_out;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_checks = 0;
  int    n_fail   = 0;
  bit    done     = 1'b0;

  // bench reference state
  logic [W-1:0] ma = '0, mb = '0;
  logic pa = 1'b0, pb = 1'b0;

  task automatic step(input logic r, input logic en_n, input logic d,
                      input logic sab, input logic sba,
                      input logic [W-1:0] ai, input logic [W-1:0] bi,
                      input logic ca, input logic cb, input string tag);
    exp_t e;
    logic [W-1:0] cap_av, cap_bv;
    @(negedge clk);
    rst = r; oe_n = en_n; dir = d; sel_ab = sab; sel_ba = sba;
    a_in = ai; b_in = bi; cap_a = ca; cap_b = cb;
    #1;
    e.b_oe  = !en_n && d;
    e.a_oe  = !en_n && !d;
    e.b_out = e.b_oe ? (sab ? ma : ai) : '0;
    e.a_out = e.a_oe ? (sba ? mb : bi) : '0;
    cap_av  = e.a_oe ? e.a_out : ai;
    cap_bv  = e.b_oe ? e.b_out : bi;
    if (!r) begin
      exp_q.push_back(e);
      tag_q.push_back(tag);
    end
    @(posedge clk);
    if (r) begin
      ma = '0; mb = '0;
    end else begin
      if (pa && !ca) ma = cap_av;
      if (pb && !cb) mb = cap_bv;
    end
    pa = ca; pb = cb;
  endtask

  // monitor: compare the cycle's expectation at a point away from the edges
  initial begin
    exp_t e, got;
    string t;
    forever begin
      @(negedge clk);
      #2;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        got = '{a_oe: a_oe, b_oe: b_oe, a_out: a_out, b_out: b_out};
        n_checks++;
        if (got !== e) begin
          n_fail++;
          $display("FAIL %s: got a_oe=%b b_oe=%b a_out=%h b_out=%h, expected a_oe=%b b_oe=%b a_out=%h b_out=%h",
                   t, got.a_oe, got.b_oe, got.a_out, got.b_out,
                   e.a_oe, e.b_oe, e.a_out, e.b_out);
        end
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; oe_n = 1'b1; dir = 1'b0; sel_ab = 1'b0; sel_ba = 1'b0;
    cap_a = 1'b0; cap_b = 1'b0; a_in = '0; b_in = '0;
    repeat (3) step(1, 1, 0, 0, 0, 8'h00, 8'h00, 0, 0, "reset");

    // R1: stored registers read zero after reset
    step(0, 0, 1, 1, 0, 8'h99, 8'h66, 0, 0, "R1 stored A");
    step(0, 0, 0, 0, 1, 8'h99, 8'h66, 0, 0, "R1 stored B");

    // R8: load both registers while disabled
    step(0, 1, 0, 0, 0, 8'h5A, 8'hC3, 1, 1, "R2 disabled");
    step(0, 1, 1, 1, 1, 8'h5A, 8'hC3, 0, 0, "R8 load disabled");
    step(0, 0, 1, 1, 0, 8'h00, 8'h00, 0, 0, "R8 readback A");
    step(0, 0, 0, 0, 1, 8'h00, 8'h00, 0, 0, "R8 readback B");

    // R2 R3 R4 R5: every enable/direction/select combination
    for (int k = 0; k < 16; k++) begin
      step(0, k[3], k[2], k[1], k[0], 8'h3C, 8'hA5, 0, 0,
           k[3] ? "R2 combo" : (k[2] ? "R3 R4 combo" : "R3 R5 combo"));
    end

    // R7: rising strobe and held-high strobe do not load
    step(0, 0, 1, 1, 0, 8'hFF, 8'h11, 1, 0, "R7 rise A");
    step(0, 0, 1, 1, 0, 8'h0F, 8'h11, 1, 0, "R7 high A");
    step(0, 0, 1, 1, 0, 8'h0F, 8'h11, 1, 0, "R7 hold A");
    // R6: falling strobe loads the current A value
    step(0, 0, 1, 1, 0, 8'hE1, 8'h11, 0, 0, "R6 fall A");
    step(0, 0, 1, 1, 0, 8'h00, 8'h11, 0, 0, "R6 readback A");
    step(0, 0, 0, 1, 1, 8'h00, 8'h22, 0, 1, "R7 rise B");
    step(0, 0, 0, 1, 1, 8'h00, 8'h33, 0, 0, "R6 fall B");
    step(0, 0, 0, 1, 1, 8'h00, 8'h44, 0, 0, "R6 readback B");

    // R9: A driven with live B; A register captures the driven value
    step(0, 0, 0, 0, 0, 8'h11, 8'h77, 1, 0, "R9 drive A");
    step(0, 0, 0, 0, 0, 8'h11, 8'h77, 0, 0, "R9 fall A");
    step(0, 0, 1, 1, 0, 8'h11, 8'h00, 0, 0, "R9 readback A");
    // R9: B driven from stored A; B register captures that value
    step(0, 0, 1, 1, 0, 8'h00, 8'h00, 0, 1, "R9 drive B");
    step(0, 0, 1, 1, 0, 8'h00, 8'hBB, 0, 0, "R9 fall B");
    step(0, 0, 0, 0, 1, 8'h00, 8'hBB, 0, 0, "R9 readback B");

    step(0, 1, 0, 0, 0, 8'h00, 8'h00, 0, 0, "R2 final");
    @(negedge clk);
    #3;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule